// File: doc/BRIEF.md
# Single-Hart External Interrupt Controller

This block gathers four level-sensitive interrupt lines and presents them to one processor core as a single external-interrupt request. Software programs a 3-bit priority for each source, an enable mask and a priority threshold. Software then services interrupts through a claim/complete handshake. A claim read returns the ID of the most urgent eligible source and takes that source out of contention. A later write of the same ID re-arms the source. The source IDs run from 1 to 4. ID 0 means "nothing to service".

All registers are 32-bit words on a simple register bus. A read returns its data one cycle after the request. A write takes effect at the clock edge that samples it. Software is expected to read claims in a loop until it gets 0, completing each ID it handled.

Top module: `ext_irq_hub`

## Requirements
- R1: After synchronous reset, every priority, the enable mask, the threshold and every pending bit are zero. `ext_irq` is low, and a claim read returns 0.
- R2: The priority of source i (i = 1..4) is the word at byte offset 4*i. Only its low 3 bits are stored, and it reads back zero-extended. Offset 0 holds no priority: writes there are ignored and it reads as 0.
- R3: The pending word at offset 0x1000 has bit i for source i, and bit 0 is always 0. Input pin `irq_in[k]` drives source k+1. A high input sets the pending bit at the next clock edge. The pending bit stays set after the input drops. Writes to this word are ignored.
- R4: The enable word at offset 0x2000 uses the same bit numbering. Only bits 1..4 are stored. Writing 0xFF reads back as 0x1E.
- R5: The threshold word at offset 0x200000 stores 3 bits. A source is eligible when it is pending and enabled and its priority is strictly above the threshold. A priority of 0 is never eligible.
- R6: `ext_irq` is high in exactly those cycles in which at least one source is eligible. It is derived from register state without a further register stage.
- R7: A read of the claim word at offset 0x200004 returns the eligible source with the highest priority. Among eligible sources of equal priority it returns the lowest ID. It returns 0 when no source is eligible.
- R8: A claim that returns a nonzero ID clears that source's pending bit. Until the ID is written back to the claim word, a still-high input does not set the pending bit again. After the write-back, a high input sets it again.
- R9: Some writes have no effect. These are a write of an ID to the claim word while that ID is not claimed, a write of 0 to the claim word, and writes to unmapped offsets. Reads of unmapped offsets return 0.
- R10: `bus_rvalid` is high in the cycle after each read request, and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 4 | Level interrupt inputs; bit k is source k+1 |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 22 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid (one cycle after a read request) |
| bus_rdata | output | 32 | Read data |
| ext_irq | output | 1 | External-interrupt request to the core |

## Verification
The hardest state to reach is a source that has been claimed but not yet completed while its input stays high. Only in that state do the claimed flag and the level input pull against each other, and it is visible only indirectly through the pending word and `ext_irq`. The bench holds the input high across the claim read and then reads the pending word and a second claim. It writes back a wrong ID and checks that nothing changes. Only then does it write back the correct ID and wait for the pending bit to return. A table of arbitration cases covers ties, masking, thresholds and zero priorities, with a reset between entries.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned OFS_PEND  = 32'h0000_1000;
  localparam int unsigned OFS_EN    = 32'h0000_2000;
  localparam int unsigned OFS_THR   = 32'h0020_0000;
  localparam int unsigned OFS_CLAIM = 32'h0020_0004;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_PRIO,
    RK_PEND,
    RK_EN,
    RK_THR,
    RK_CLAIM
  } reg_kind_e;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int N_SRC  = 4,
  parameter int ADDR_W = 22,
  localparam int ID_W  = $clog2(N_SRC + 1)
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [ID_W-1:0]   src
);

  localparam int WORD_W = ADDR_W - 2;

  always_comb begin
    kind = RK_NONE;
    src  = addr[ID_W+1:2];
    if (addr == ADDR_W'(OFS_PEND))       kind = RK_PEND;
    else if (addr == ADDR_W'(OFS_EN))    kind = RK_EN;
    else if (addr == ADDR_W'(OFS_THR))   kind = RK_THR;
    else if (addr == ADDR_W'(OFS_CLAIM)) kind = RK_CLAIM;
    else if (addr[1:0] == 2'b00 &&
             addr[ADDR_W-1:2] != '0 &&
             addr[ADDR_W-1:2] <= WORD_W'(N_SRC))
      kind = RK_PRIO;
  end

endmodule

// File: rtl/irqc_gateway.sv
module irqc_gateway (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic take,
  input  logic done,
  output logic pending,
  output logic inflight
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      inflight <= 1'b0;
    end else if (take) begin
      pending  <= 1'b0;
      inflight <= 1'b1;
    end else if (done && inflight) begin
      inflight <= 1'b0;
    end else if (level && !inflight && !pending) begin
      pending  <= 1'b1;
    end
  end

endmodule

// File: rtl/irqc_select.sv
module irqc_select #(
  parameter int N_SRC  = 4,
  parameter int PRIO_W = 3,
  localparam int ID_W  = $clog2(N_SRC + 1)
) (
  input  logic [N_SRC-1:0]        pend,
  input  logic [N_SRC-1:0]        en,
  input  logic [N_SRC*PRIO_W-1:0] prio_flat,
  input  logic [PRIO_W-1:0]       thr,
  output logic [ID_W-1:0]         best_id,
  output logic                    any_elig
);

  logic [PRIO_W-1:0] best_p;

  // Strict ">" starting from the threshold: filters low priorities
  // and lets the lowest ID keep a tie.
  always_comb begin
    best_id = '0;
    best_p  = thr;
    for (int i = 0; i < N_SRC; i++) begin
      if (pend[i] && en[i] && prio_flat[i*PRIO_W +: PRIO_W] > best_p) begin
        best_p  = prio_flat[i*PRIO_W +: PRIO_W];
        best_id = ID_W'(i + 1);
      end
    end
  end

  assign any_elig = (best_id != '0);

endmodule

// File: rtl/ext_irq_hub.sv
module ext_irq_hub
  import irqc_pkg::*;
#(
  parameter int N_SRC  = 4,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 22,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  irq_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rvalid,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ext_irq
);

  localparam int ID_W = $clog2(N_SRC + 1);

  reg_kind_e              kind;
  logic [ID_W-1:0]        dec_src;
  logic                   wr_hit, rd_hit;
  logic [N_SRC*PRIO_W-1:0] prio_flat;
  logic [N_SRC:1]         en_q;
  logic [PRIO_W-1:0]      thr_q;
  logic [N_SRC-1:0]       pend_src, infl_src;
  logic [ID_W-1:0]        best_id;
  logic                   any_elig;
  logic                   claim_take, complete_ok;
  logic [DATA_W-1:0]      rd_word;
  logic [N_SRC:0]         pend_vec, en_vec, claimed_vec;

  assign wr_hit = bus_sel && bus_wr;
  assign rd_hit = bus_sel && !bus_wr;

  irqc_decode #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .kind (kind),
    .src  (dec_src)
  );

  // Priority registers, one per source
  for (genvar i = 1; i <= N_SRC; i++) begin : g_prio
    logic [PRIO_W-1:0] p_q;
    always_ff @(posedge clk) begin
      if (rst)
        p_q <= '0;
      else if (wr_hit && kind == RK_PRIO && dec_src == ID_W'(i))
        p_q <= bus_wdata[PRIO_W-1:0];
    end
    assign prio_flat[(i-1)*PRIO_W +: PRIO_W] = p_q;
  end

  // Enable mask and threshold
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      thr_q <= '0;
    end else if (wr_hit) begin
      if (kind == RK_EN)  en_q  <= bus_wdata[N_SRC:1];
      if (kind == RK_THR) thr_q <= bus_wdata[PRIO_W-1:0];
    end
  end

  irqc_select #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_select (
    .pend      (pend_src),
    .en        (en_q),
    .prio_flat (prio_flat),
    .thr       (thr_q),
    .best_id   (best_id),
    .any_elig  (any_elig)
  );

  assign claim_take  = rd_hit && kind == RK_CLAIM && any_elig;
  assign complete_ok = wr_hit && kind == RK_CLAIM && bus_wdata != '0 &&
                       bus_wdata <= DATA_W'(N_SRC);

  for (genvar i = 1; i <= N_SRC; i++) begin : g_src
    irqc_gateway u_gw (
      .clk      (clk),
      .rst      (rst),
      .level    (irq_in[i-1]),
      .take     (claim_take && best_id == ID_W'(i)),
      .done     (complete_ok && bus_wdata[ID_W-1:0] == ID_W'(i)),
      .pending  (pend_src[i-1]),
      .inflight (infl_src[i-1])
    );
  end

  assign pend_vec    = {pend_src, 1'b0};
  assign en_vec      = {en_q, 1'b0};
  assign claimed_vec = {infl_src, 1'b0};

  always_comb begin
    rd_word = '0;
    case (kind)
      RK_PRIO: begin
        for (int i = 1; i <= N_SRC; i++)
          if (dec_src == ID_W'(i))
            rd_word = DATA_W'(prio_flat[(i-1)*PRIO_W +: PRIO_W]);
      end
      RK_PEND:  rd_word = DATA_W'(pend_vec);
      RK_EN:    rd_word = DATA_W'(en_vec);
      RK_THR:   rd_word = DATA_W'(thr_q);
      RK_CLAIM: rd_word = DATA_W'(best_id);
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_hit;
      if (rd_hit) bus_rdata <= rd_word;
    end
  end

  assign ext_irq = any_elig;

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int N_SRC = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           bus_sel,
  input logic           bus_wr,
  input logic           bus_rvalid,
  input logic           ext_irq,
  input logic [N_SRC:0] pend_vec,
  input logic [N_SRC:0] en_vec,
  input logic [N_SRC:0] claimed_vec
);

  // R10
  rvalid_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr) |=> bus_rvalid);

  // R10
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> !bus_rvalid);

  // R6
  irq_needs_source_chk: assert property (@(posedge clk) disable iff (rst)
    ext_irq |-> (pend_vec & en_vec) != '0);

  // R8
  claimed_not_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_vec & claimed_vec) == '0);

  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pend_vec == '0 && en_vec == '0 && !ext_irq));

  // R3
  pend_bit0_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !pend_vec[0] && !claimed_vec[0]);

endmodule

bind ext_irq_hub irqc_chk #(.N_SRC(N_SRC)) u_irqc_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_rvalid  (bus_rvalid),
  .ext_irq     (ext_irq),
  .pend_vec    (pend_vec),
  .en_vec      (en_vec),
  .claimed_vec (claimed_vec)
);

// File: tb/test_ext_irq_hub.sv
module test_ext_irq_hub;

  localparam int CLK_NS = 10;
  localparam logic [21:0] A_PEND  = 22'h001000;
  localparam logic [21:0] A_EN    = 22'h002000;
  localparam logic [21:0] A_THR   = 22'h200000;
  localparam logic [21:0] A_CLAIM = 22'h200004;

  // {exp_irq, exp_id, irq, thr, en, p4, p3, p2, p1}
  localparam logic [27:0] VEC_TBL [10] = '{
    {1'b1, 3'd4, 4'hF, 3'd0, 5'h1E, 3'd4, 3'd3, 3'd2, 3'd1},
    {1'b1, 3'd1, 4'hF, 3'd0, 5'h1E, 3'd1, 3'd2, 3'd5, 3'd5},
    {1'b0, 3'd0, 4'hF, 3'd3, 5'h1E, 3'd3, 3'd3, 3'd3, 3'd3},
    {1'b0, 3'd0, 4'hF, 3'd0, 5'h1E, 3'd0, 3'd0, 3'd0, 3'd0},
    {1'b1, 3'd3, 4'hF, 3'd0, 5'h1A, 3'd1, 3'd6, 3'd6, 3'd2},
    {1'b0, 3'd0, 4'h6, 3'd6, 5'h1E, 3'd7, 3'd1, 3'd1, 3'd7},
    {1'b1, 3'd1, 4'h7, 3'd3, 5'h1E, 3'd7, 3'd4, 3'd4, 3'd4},
    {1'b0, 3'd0, 4'h0, 3'd0, 5'h1E, 3'd4, 3'd3, 3'd2, 3'd1},
    {1'b0, 3'd0, 4'hF, 3'd0, 5'h01, 3'd4, 3'd3, 3'd2, 3'd1},
    {1'b1, 3'd3, 4'hC, 3'd1, 5'h1E, 3'd5, 3'd5, 3'd2, 3'd2}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  irq_in = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [21:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic        ext_irq;

  int total = 0;
  int bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  ext_irq_hub i_ext_irq_hub (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .ext_irq(ext_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; irq_in = '0; bus_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [21:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [21:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    check("R10 rvalid after read", 32'(bus_rvalid), 32'd1);
    d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    do_reset();

    // R1 reset state
    check("R1 ext_irq after reset", 32'(ext_irq), 32'd0);
    rd(22'h4, d);    check("R1 prio1 reset", d, 32'd0);
    rd(A_PEND, d);   check("R1 pending reset", d, 32'd0);
    rd(A_EN, d);     check("R1 enable reset", d, 32'd0);
    rd(A_THR, d);    check("R1 threshold reset", d, 32'd0);
    rd(A_CLAIM, d);  check("R1 claim reset", d, 32'd0);
    wait_cyc(1);
    check("R10 rvalid idle", 32'(bus_rvalid), 32'd0);

    // Table of arbitration cases (R5, R6, R7)
    for (int v = 0; v < 10; v++) begin
      logic [27:0] e;
      e = VEC_TBL[v];
      do_reset();
      wr(22'h4,  32'(e[2:0]));
      wr(22'h8,  32'(e[5:3]));
      wr(22'hC,  32'(e[8:6]));
      wr(22'h10, 32'(e[11:9]));
      wr(A_EN,  32'(e[16:12]));
      wr(A_THR, 32'(e[19:17]));
      irq_in = e[23:20];
      wait_cyc(2);
      check($sformatf("R6 ext_irq vector %0d", v), 32'(ext_irq), 32'(e[27]));
      rd(A_CLAIM, d);
      check($sformatf("R7 R5 claim vector %0d", v), d, 32'(e[26:24]));
    end

    // R2 priority width, offset 0 ignored
    do_reset();
    wr(22'h8, 32'hFF);
    rd(22'h8, d); check("R2 prio zero-extended", d, 32'd7);
    wr(22'h0, 32'h5);
    rd(22'h0, d); check("R2 offset 0 reads zero", d, 32'd0);
    rd(22'h4, d); check("R2 offset 0 write no effect on prio1", d, 32'd0);

    // R4 enable bits
    wr(A_EN, 32'hFF);
    rd(A_EN, d); check("R4 enable readback", d, 32'h1E);

    // R5 threshold width
    wr(A_THR, 32'hF);
    rd(A_THR, d); check("R5 threshold readback", d, 32'd7);

    // R3 pin mapping, hold after drop, write ignored
    do_reset();
    irq_in = 4'b0100;
    wait_cyc(2);
    irq_in = '0;
    wait_cyc(1);
    rd(A_PEND, d); check("R3 pin2 -> pending bit3 held", d, 32'h08);
    wr(A_PEND, 32'h0);
    rd(A_PEND, d); check("R3 pending write ignored", d, 32'h08);

    // R8 / R9 claim-complete handshake
    do_reset();
    wr(22'h4, 32'd1);
    wr(A_EN, 32'h02);
    irq_in = 4'b0001;
    wait_cyc(2);
    check("R6 ext_irq source1", 32'(ext_irq), 32'd1);
    rd(A_CLAIM, d); check("R8 first claim", d, 32'd1);
    wait_cyc(3);
    rd(A_PEND, d);  check("R8 no re-pend while claimed", d, 32'h0);
    check("R8 ext_irq low while claimed", 32'(ext_irq), 32'd0);
    rd(A_CLAIM, d); check("R8 second claim empty", d, 32'd0);
    wr(A_CLAIM, 32'd2);
    wr(A_CLAIM, 32'd0);
    wait_cyc(2);
    rd(A_PEND, d);  check("R9 wrong-ID complete ignored", d, 32'h0);
    wr(22'h3000, 32'hFFFF_FFFF);
    rd(22'h3000, d); check("R9 unmapped read zero", d, 32'd0);
    rd(A_EN, d);     check("R9 unmapped write no effect", d, 32'h02);
    rd(22'h4, d);    check("R9 unmapped write prio intact", d, 32'd1);
    wr(A_CLAIM, 32'd1);
    wait_cyc(2);
    rd(A_PEND, d);  check("R8 re-pend after complete", d, 32'h02);
    check("R8 ext_irq after complete", 32'(ext_irq), 32'd1);

    // Drain loop: claims until 0 (R7, R8)
    do_reset();
    wr(22'h4, 32'd2); wr(22'h8, 32'd2); wr(22'hC, 32'd6); wr(22'h10, 32'd1);
    wr(A_EN, 32'h1E);
    irq_in = 4'hF;
    wait_cyc(2);
    irq_in = '0;
    rd(A_CLAIM, d); check("R7 drain 1st", d, 32'd3);
    rd(A_CLAIM, d); check("R7 drain 2nd tie", d, 32'd1);
    rd(A_CLAIM, d); check("R7 drain 3rd", d, 32'd2);
    rd(A_CLAIM, d); check("R7 drain 4th", d, 32'd4);
    rd(A_CLAIM, d); check("R7 drain end", d, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule